// File: doc/BRIEF.md
# Keyed Watchdog Timer with Coded Intervals

This block is a countdown watchdog behind a small write-only 32-bit register port. Software arms it through a mode register that holds an enable bit, a reset-enable bit and a 4-bit interval code. From then on it must keep the timer alive. It does this with writes to a control register, and a write only counts when it carries a 12-bit key pattern together with the restart bit. If the countdown runs out, the block either pulses a one-cycle system reset request or raises a sticky interrupt flag. A configuration register picks which of the two happens.

The countdown advances only on cycles where the prescaled `tick` input is high. The half-second timeout equals the parameter `HALF_TICKS` tick pulses, and every longer interval is an integer multiple of that count. The parameter `LAYOUT` chooses where the interval code sits inside the mode register: bits 6:3 (value 0) or bits 7:4 (value 1).

Top module: `keyguard_wdt`

## Requirements
- R1: After reset, `rst_pulse` and `irq` are low and the timer is stopped, so no expiry event occurs until the mode register is written with the enable bit set.
- R2: A write to the mode register (byte offset 0x4) with bit 0 set loads the counter from the interval code in bits 6:3 (LAYOUT 0). Expiry follows after exactly that many tick pulses.
- R3: Interval codes 0 to 11 select 1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28 and 32 half-second units of `HALF_TICKS` ticks each. Codes 12 to 15 select 32 units.
- R4: A write to the control register (byte offset 0x0) that has bit 0 set and 0xA57 in bits 12:1 reloads the counter from the stored interval while the timer is enabled.
- R5: A control write with any other key value, or with bit 0 clear, is ignored, and the original expiry time stands.
- R6: When the config register (byte offset 0x8, bits 1:0) holds 2, expiry sets `irq`, which stays high, and `rst_pulse` stays low. For any other value, expiry drives `rst_pulse` high for exactly one cycle.
- R7: When the reset-enable bit (mode bit 1) is clear, an expiry under the reset action produces no `rst_pulse`.
- R8: A mode write with bit 0 clear stops the counter and clears `irq` on the next cycle. No expiry follows.
- R9: Each expiry produces exactly one event. The counter then rests at zero until it is reloaded.
- R10: The counter holds its value on cycles where `tick` is low.
- R11: A keyed restart or an enabling mode write that falls in the same cycle as the final tick wins. That cycle produces no expiry, and the counter reloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled countdown enable, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register write |
| wdata | input | DATA_W | Register write data |
| rst_pulse | output | 1 | One-cycle system reset request on expiry |
| irq | output | 1 | Sticky expiry interrupt flag |

## Verification
Two events can land in the same cycle: the final tick, which would expire the counter, and a bus write that reloads it. That write can be a keyed restart or a mode write that re-enables. The bench arms the shortest interval with `tick` held high, waits two idle cycles, and issues the write so that the bus samples it on the exact edge where the counter would go from one to zero. The scoreboard then expects no event at that edge and exactly one event a full interval later. Any early or doubled event is reported by cycle number.

// File: rtl/kgw_pkg.sv
package kgw_pkg;

   localparam logic [11:0] RESTART_KEY = 12'hA57;
   localparam int          KEY_LSB     = 1;
   localparam int          KEY_W       = 12;
   localparam int          RESTART_BIT = 0;
   localparam int          EN_BIT      = 0;
   localparam int          RSTEN_BIT   = 1;
   localparam int          UNIT_W      = 6;
   localparam logic [1:0]  ACT_IRQ     = 2'd2;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_MODE = 2'd1,
      SEL_CFG  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic       en;
      logic       rst_en;
      logic [3:0] code;
   } mode_t;

   // interval code to number of half-second units
   function automatic logic [UNIT_W-1:0] half_units(input logic [3:0] code);
      logic [UNIT_W-1:0] u;
      case (code)
         4'd0:    u = 6'd1;
         4'd1:    u = 6'd2;
         4'd2:    u = 6'd4;
         4'd3:    u = 6'd6;
         4'd4:    u = 6'd8;
         4'd5:    u = 6'd10;
         4'd6:    u = 6'd12;
         4'd7:    u = 6'd16;
         4'd8:    u = 6'd20;
         4'd9:    u = 6'd24;
         4'd10:   u = 6'd28;
         default: u = 6'd32;
      endcase
      return u;
   endfunction

endpackage

// File: rtl/kgw_regs.sv
module kgw_regs
   import kgw_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 32,
   parameter int LAYOUT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              restart_req,
   output logic              mode_wr,
   output mode_t             mode_new,
   output mode_t             mode_q,
   output logic              act_irq
);

   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   reg_sel_e          sel;
   logic [3:0]        code_field;
   logic [1:0]        cfg_q;

   assign word = addr[ADDR_W-1:2];

   always_comb begin
      if      (word == WORD_W'(0)) sel = SEL_CTRL;
      else if (word == WORD_W'(1)) sel = SEL_MODE;
      else if (word == WORD_W'(2)) sel = SEL_CFG;
      else                         sel = SEL_NONE;
   end

   generate
      if (LAYOUT == 0) begin : g_code_lo
         assign code_field = wdata[6:3];
      end else begin : g_code_hi
         assign code_field = wdata[7:4];
      end
   endgenerate

   assign restart_req = wr_en && (sel == SEL_CTRL) && wdata[RESTART_BIT]
                        && (wdata[KEY_LSB +: KEY_W] == RESTART_KEY);
   assign mode_wr     = wr_en && (sel == SEL_MODE);

   assign mode_new.en     = wdata[EN_BIT];
   assign mode_new.rst_en = wdata[RSTEN_BIT];
   assign mode_new.code   = code_field;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         cfg_q  <= '0;
      end else begin
         if (mode_wr)                     mode_q <= mode_new;
         if (wr_en && (sel == SEL_CFG))   cfg_q  <= wdata[1:0];
      end
   end

   assign act_irq = (cfg_q == ACT_IRQ);

   logic unused_bits;
   assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:KEY_LSB+KEY_W]};

   // a restart request can only come from a write carrying the exact key
   a_r4_key_required: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req |-> (wr_en && wdata[12:1] == 12'hA57 && wdata[0]));

   // a_r6: config writes never alter the stored mode
   a_r6_cfg_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_wr |=> $stable(mode_q));

endmodule

// File: rtl/kgw_interval.sv
module kgw_interval
   import kgw_pkg::*;
#(
   parameter int HALF_TICKS = 16384,
   parameter int CNT_W      = 20
) (
   input  logic [3:0]       code,
   output logic [CNT_W-1:0] load_val
);

   logic [UNIT_W-1:0] units;

   assign units    = half_units(code);
   assign load_val = CNT_W'(HALF_TICKS) * {{(CNT_W-UNIT_W){1'b0}}, units};

   // R3: every code gives a nonzero whole multiple of the half-second count
   always_comb begin
      a_r3_nonzero_load: assert (load_val != '0);
   end

endmodule

// File: rtl/kgw_counter.sv
module kgw_counter #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             load,
   input  logic             stop,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt <= '0;
      else if (stop)                      cnt <= '0;
      else if (load)                      cnt <= load_val;
      else if (tick && cnt != '0)         cnt <= cnt - CNT_W'(1);
   end

   assign expire = tick && (cnt == CNT_W'(1)) && !load && !stop;

   a_r10_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load && !stop) |=> $stable(cnt));

   a_r9_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == '0 && !load) |=> (cnt == '0));

   a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (cnt == '0));

   a_r9_expire_then_zero: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (cnt == '0));

endmodule

// File: rtl/kgw_action.sv
module kgw_action (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic act_irq,
   input  logic rst_en,
   input  logic clear,
   output logic rst_pulse,
   output logic irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pulse <= 1'b0;
         irq       <= 1'b0;
      end else begin
         rst_pulse <= expire && !act_irq && rst_en;
         if (clear)                  irq <= 1'b0;
         else if (expire && act_irq) irq <= 1'b1;
      end
   end

   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clear) |=> irq);

   a_r7_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> $past(rst_en && expire));

   a_r6_irq_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> $past(!act_irq));

endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
   import kgw_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 32,
   parameter int HALF_TICKS = 16384,
   parameter int LAYOUT     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              rst_pulse,
   output logic              irq
);

   localparam int MAX_TICKS = HALF_TICKS * 32;
   localparam int CNT_W     = $clog2(MAX_TICKS + 1);

   if (HALF_TICKS < 1) begin : g_bad_half
      $error("HALF_TICKS must be at least 1");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W must cover three word registers");
   end
   if (DATA_W < KEY_LSB + KEY_W + 1) begin : g_bad_data
      $error("DATA_W too narrow for the key field");
   end
   if (LAYOUT != 0 && LAYOUT != 1) begin : g_bad_layout
      $error("LAYOUT must be 0 or 1");
   end
   if (CNT_W < UNIT_W) begin : g_bad_cnt
      $error("counter width below unit width");
   end

   logic             restart_req;
   logic             mode_wr;
   mode_t            mode_new;
   mode_t            mode_q;
   logic             act_irq;
   logic [3:0]       code_sel;
   logic [CNT_W-1:0] load_val;
   logic             load;
   logic             stop;
   logic             expire;

   kgw_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LAYOUT (LAYOUT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .addr        (addr),
      .wdata       (wdata),
      .restart_req (restart_req),
      .mode_wr     (mode_wr),
      .mode_new    (mode_new),
      .mode_q      (mode_q),
      .act_irq     (act_irq)
   );

   // a new mode write selects its own code, a restart reuses the stored one
   assign code_sel = mode_wr ? mode_new.code : mode_q.code;

   kgw_interval #(
      .HALF_TICKS (HALF_TICKS),
      .CNT_W      (CNT_W)
   ) u_interval (
      .code     (code_sel),
      .load_val (load_val)
   );

   assign stop = mode_wr && !mode_new.en;
   assign load = (mode_wr && mode_new.en) || (restart_req && mode_q.en);

   kgw_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .load     (load),
      .stop     (stop),
      .load_val (load_val),
      .expire   (expire)
   );

   kgw_action u_action (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .act_irq   (act_irq),
      .rst_en    (mode_q.rst_en),
      .clear     (stop),
      .rst_pulse (rst_pulse),
      .irq       (irq)
   );

   a_r11_reload_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !rst_pulse);

   a_r8_disable_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> !irq);

   a_r5_bad_write_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[ADDR_W-1:2] == '0 && !restart_req) |-> !load);

endmodule

// File: tb/keyguard_wdt_tb.sv
`timescale 1ns/1ps
module keyguard_wdt_tb;

   localparam int HALF = 3;
   localparam int K_RST = 0;
   localparam int K_IRQ = 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        rst_pulse;
   logic        irq;

   always #4 clk = ~clk;

   keyguard_wdt #(
      .ADDR_W (4), .DATA_W (32), .HALF_TICKS (HALF), .LAYOUT (0)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .tick (tick), .wr_en (wr_en),
      .addr (addr), .wdata (wdata), .rst_pulse (rst_pulse), .irq (irq)
   );

   int    cyc = 0;
   int    n_chk = 0;
   int    n_fail = 0;
   bit    done = 1'b0;
   bit    mon_on = 1'b0;
   bit    irq_prev = 1'b0;
   int    q_cyc[$];
   int    q_kind[$];
   string q_req[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int units(input int code);
      int t[12] = '{1, 2, 4, 6, 8, 10, 12, 16, 20, 24, 28, 32};
      return (code > 11) ? 32 : t[code];
   endfunction

   function automatic logic [31:0] mode_w(input bit en, input bit re, input int code);
      return (32'(code) << 3) | (32'(re) << 1) | 32'(en);
   endfunction

   function automatic logic [31:0] ctrl_w(input int key, input bit go);
      return (32'(key) << 1) | 32'(go);
   endfunction

   // driver: one write per call, returns the cycle of the sampling edge
   task automatic wr(input logic [3:0] a, input logic [31:0] d, output int wc);
      addr  = a;
      wdata = d;
      wr_en = 1'b1;
      @(posedge clk);
      #1 wc = cyc;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_ev(input int kind, input int at, input string req);
      q_kind.push_back(kind);
      q_cyc.push_back(at);
      q_req.push_back(req);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain(input int n, input string req);
      idle(n);
      check(q_cyc.size() == 0, req, "expected events still pending", q_cyc.size(), 0);
   endtask

   // monitor: pops the scoreboard whenever the design reports an expiry
   task automatic take(input int kind);
      int    c;
      int    k;
      string r;
      if (q_cyc.size() == 0) begin
         check(1'b0, "R7 R8 R9", "unexpected event kind", kind, -1);
      end else begin
         c = q_cyc.pop_front();
         k = q_kind.pop_front();
         r = q_req.pop_front();
         check(k == kind, r, "event kind", kind, k);
         check(c == cyc, r, "event cycle", cyc, c);
      end
   endtask

   always @(negedge clk) begin
      if (mon_on) begin
         if (rst_pulse)           take(K_RST);
         if (irq && !irq_prev)    take(K_IRQ);
      end
      irq_prev = irq;
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int wc;
      int rc;
      int r;
      int codes[6] = '{1, 2, 7, 11, 12, 15};
      idle(5);
      rst_n = 1'b1;
      idle(1);
      mon_on = 1'b1;

      // R1: quiet after reset
      check(rst_pulse == 1'b0, "R1", "rst_pulse after reset", rst_pulse, 0);
      check(irq == 1'b0, "R1", "irq after reset", irq, 0);
      tick = 1'b1;
      drain(20, "R1");

      // R2 / R3 code 0, reset action, single pulse and no repeat (R6, R9)
      wr(4'h8, 32'd0, wc);
      wr(4'h4, mode_w(1, 1, 0), wc);
      expect_ev(K_RST, wc + HALF * units(0), "R2");
      drain(30, "R9");

      // R3: interval sweep
      foreach (codes[i]) begin
         wr(4'h4, mode_w(1, 1, codes[i]), wc);
         expect_ev(K_RST, wc + HALF * units(codes[i]), "R3");
         drain(HALF * units(codes[i]) + 6, "R3");
      end

      // R4: keyed restart moves expiry
      wr(4'h4, mode_w(1, 1, 4), wc);
      idle(9);
      wr(4'h0, ctrl_w(12'hA57, 1), rc);
      expect_ev(K_RST, rc + HALF * units(4), "R4");
      drain(HALF * units(4) + 6, "R4");

      // R5: wrong key and missing restart bit are ignored
      wr(4'h4, mode_w(1, 1, 2), wc);
      wr(4'h0, ctrl_w(12'hA56, 1), rc);
      wr(4'h0, ctrl_w(12'hA57, 0), rc);
      expect_ev(K_RST, wc + HALF * units(2), "R5");
      drain(HALF * units(2) + 6, "R5");

      // R6: interrupt action, sticky; then R8 disable clears it
      wr(4'h8, 32'd2, wc);
      wr(4'h4, mode_w(1, 1, 1), wc);
      expect_ev(K_IRQ, wc + HALF * units(1), "R6");
      drain(HALF * units(1) + 10, "R6");
      check(irq == 1'b1, "R6", "irq sticky", irq, 1);
      check(rst_pulse == 1'b0, "R6", "no reset in irq mode", rst_pulse, 0);
      wr(4'h4, mode_w(0, 0, 1), wc);
      check(irq == 1'b0, "R8", "irq cleared by disable", irq, 0);
      drain(20, "R8");

      // R6: another config value selects the reset action
      wr(4'h8, 32'd1, wc);
      wr(4'h4, mode_w(1, 1, 0), wc);
      expect_ev(K_RST, wc + HALF * units(0), "R6");
      drain(12, "R6");

      // R7: reset-enable clear suppresses the pulse
      wr(4'h8, 32'd0, wc);
      wr(4'h4, mode_w(1, 0, 0), wc);
      drain(20, "R7");

      // R8: disable mid-count, no expiry afterwards
      wr(4'h4, mode_w(1, 1, 3), wc);
      idle(5);
      wr(4'h4, mode_w(0, 1, 3), wc);
      drain(40, "R8");

      // R10: counting only on ticks
      tick = 1'b0;
      wr(4'h4, mode_w(1, 1, 0), wc);
      drain(25, "R10");
      tick = 1'b1;
      r = cyc + 1;
      expect_ev(K_RST, r + HALF * units(0) - 1, "R10");
      drain(12, "R10");

      // R11: keyed restart on the final tick edge
      wr(4'h4, mode_w(1, 1, 0), wc);
      idle(2);
      wr(4'h0, ctrl_w(12'hA57, 1), rc);
      check(rc == wc + HALF, "R11", "restart edge placement", rc, wc + HALF);
      expect_ev(K_RST, rc + HALF * units(0), "R11");
      drain(12, "R11");

      // R11: enabling mode write on the final tick edge
      wr(4'h4, mode_w(1, 1, 0), wc);
      idle(2);
      wr(4'h4, mode_w(1, 1, 1), rc);
      check(rc == wc + HALF, "R11", "mode edge placement", rc, wc + HALF);
      expect_ev(K_RST, rc + HALF * units(1), "R11");
      drain(HALF * units(1) + 6, "R11");

      if (!done) begin
         done = 1'b1;
         summary();
         $finish;
      end
   end

endmodule